// File: doc/BRIEF.md
# Modulo Up-Counter Timer

A 16-bit up-counting timer on a simple 32-bit register bus. Software selects whether the counter runs and sets a power-of-two prescaler on the system clock. It programs a lower bound (the start value) and an upper bound (the modulo value). The counter climbs from the start value to the modulo value, then reloads the start value. That reload raises a sticky overflow flag, which can drive a level interrupt.

Writes to the modulo and start-value registers land in a holding buffer. The active copies take the buffered values only while the counter clock is switched off. Any write to the count register snaps the counter back to the active start value, so software can restart a period at a known point. A one-shot or periodic event source is built by stopping the clock, forcing a reload, programming the modulo to the period minus one and starting the clock again.

The bus has a write strobe, a byte address and write data. Reads are combinational on the address.

Top module: `modtimer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The control word at address 0x00 has these fields: prescaler exponent in bits [2:0], clock select in bits [4:3], interrupt enable in bit 6 and overflow flag in bit 7. Bit 5 and bits [31:8] read 0.
- R3: With clock select 1 and prescaler exponent k, the counter advances once every 2^k system clocks. The prescaler phase is cleared while the clock is off, so the first advance comes 2^k clocks after the enabling write.
- R4: On an advance where the count equals the active modulo value, the counter loads the active start value and the overflow flag is set. Otherwise it adds one, so a period lasts modulo minus start plus one advances.
- R5: Any clock-select value other than 1 stops the counter. Its count stays unchanged unless the count register is written.
- R6: A write to the count register (0x04) loads the active start value on the next clock, whatever the data. This takes priority over a same-cycle advance, and that advance sets no flag.
- R7: A control write with bit 7 = 0 clears the overflow flag. A write with bit 7 = 1 leaves the flag unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R8: Writes to the modulo (0x08) and start-value (0x4C) registers go to buffers, and reads of those addresses return the buffered value. The active values copy the buffers only on clocks where clock select is 0.
- R9: Only the low 16 bits of the count, modulo and start registers are stored, and the upper 16 bits read 0. Unmapped addresses read 0.
- R10: `irq` is high exactly when both the overflow flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest case to reach from the ports is a flag clear landing on the exact clock of an overflow. The bench runs a two-state period with no prescaling and issues a clear on every cycle, so some clears must meet a reload. A second hard case is a buffered modulo write that must stay inactive while counting. The stimulus writes new bounds while the clock runs and checks the old period continues until the clock is stopped. Random mixes of prescaler, select, bound and count writes are compared each cycle against a bench model.

// File: rtl/modtimer.sv
module modtimer #(
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int PHW = (1 << PSW) - 1;
  localparam logic [AW-1:0] A_CTL  = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT  = AW'(8'h04);
  localparam logic [AW-1:0] A_MOD  = AW'(8'h08);
  localparam logic [AW-1:0] A_INIT = AW'(8'h4C);
  localparam logic [PHW-1:0] ONES = '1;

  logic [PSW-1:0] ps_q;
  logic [1:0]     sel_q;
  logic           ie_q, flag_q;
  logic [CW-1:0]  cnt_q, mod_q, modb_q, init_q, initb_q;
  logic [PHW-1:0] ph_q;

  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire wr_cnt  = bus_wr && bus_addr == A_CNT;
  wire wr_mod  = bus_wr && bus_addr == A_MOD;
  wire wr_init = bus_wr && bus_addr == A_INIT;

  wire             run    = sel_q == 2'd1;
  wire [PSW-1:0]   shamt  = PSW'(PHW) - ps_q;
  wire [PHW-1:0]   ph_lim = ONES >> shamt;
  wire             tick   = run && ph_q >= ph_lim;
  wire             wrap   = cnt_q == mod_q;
  wire             ovf    = tick && wrap && !wr_cnt;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DW-1:CW], bus_wdata[5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      sel_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
      mod_q   <= '0;
      modb_q  <= '0;
      init_q  <= '0;
      initb_q <= '0;
      ph_q    <= '0;
    end else begin
      ph_q <= (!run || tick) ? '0 : ph_q + 1'b1;

      if (wr_cnt)    cnt_q <= init_q;
      else if (tick) cnt_q <= wrap ? init_q : cnt_q + 1'b1;

      if (wr_mod)  modb_q  <= bus_wdata[CW-1:0];
      if (wr_init) initb_q <= bus_wdata[CW-1:0];
      if (sel_q == 2'd0) begin
        mod_q  <= modb_q;
        init_q <= initb_q;
      end

      if (wr_ctl) begin
        ps_q  <= bus_wdata[PSW-1:0];
        sel_q <= bus_wdata[4:3];
        ie_q  <= bus_wdata[6];
      end

      if (ovf)                         flag_q <= 1'b1;
      else if (wr_ctl && !bus_wdata[7]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata = DW'({flag_q, ie_q, 1'b0, sel_q, ps_q});
      A_CNT:   bus_rdata = DW'(cnt_q);
      A_MOD:   bus_rdata = DW'(modb_q);
      A_INIT:  bus_rdata = DW'(initb_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && ie_q;
endmodule

module modtimer_chk #(
  parameter int CW = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [1:0]    sel_q,
  input logic          tick,
  input logic          flag_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] mod_q,
  input logic [CW-1:0] init_q
);
  wire c_wr_cnt = bus_wr && bus_addr == AW'(8'h04);
  wire c_wr_ctl = bus_wr && bus_addr == AW'(8'h00);

  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != 2'd1 && !c_wr_cnt) |=> $stable(cnt_q));

  a_r6_count_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_cnt |=> cnt_q == $past(init_q));

  a_r8_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != 2'd0) |=> ($stable(mod_q) && $stable(init_q)));

  a_r7_overflow_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == mod_q && !c_wr_cnt) |=> flag_q);

  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == mod_q && !c_wr_cnt) |=> cnt_q == $past(init_q));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_ctl && !bus_wdata[7] && !tick) |=> !flag_q);
endmodule

bind modtimer modtimer_chk #(.CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sel_q(sel_q), .tick(tick), .flag_q(flag_q),
  .cnt_q(cnt_q), .mod_q(mod_q), .init_q(init_q)
);

// File: tb/modtimer_tb.sv
module modtimer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  modtimer u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  logic [2:0]  m_ps = 0;
  logic [1:0]  m_sel = 0;
  logic        m_ie = 0, m_tof = 0;
  logic [15:0] m_cnt = 0, m_mod = 0, m_modb = 0, m_init = 0, m_initb = 0;
  int          m_ph = 0;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return {24'd0, m_tof, m_ie, 1'b0, m_sel, m_ps};
      8'h04:   return {16'd0, m_cnt};
      8'h08:   return {16'd0, m_modb};
      8'h4C:   return {16'd0, m_initb};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d, input string tag);
    bit run, tick, ovf, wcnt, wctl;
    int lim;
    logic [15:0] n_cnt;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    chk(tag, bus_rdata, m_read(a));
    chk("R10", {31'd0, irq}, {31'd0, m_tof & m_ie});
    wcnt = w && a == 8'h04;
    wctl = w && a == 8'h00;
    run  = m_sel == 2'd1;
    lim  = (1 << m_ps) - 1;
    tick = run && m_ph >= lim;
    ovf  = tick && m_cnt == m_mod && !wcnt;
    n_cnt = wcnt ? m_init : tick ? ((m_cnt == m_mod) ? m_init : m_cnt + 16'd1) : m_cnt;
    @(posedge clk);
    m_ph  = (!run || tick) ? 0 : m_ph + 1;
    m_cnt = n_cnt;
    if (m_sel == 2'd0) begin m_mod = m_modb; m_init = m_initb; end
    if (w && a == 8'h08) m_modb = d[15:0];
    if (w && a == 8'h4C) m_initb = d[15:0];
    if (ovf) m_tof = 1'b1;
    else if (wctl && !d[7]) m_tof = 1'b0;
    if (wctl) begin m_ps = d[2:0]; m_sel = d[4:3]; m_ie = d[6]; end
  endtask

  function automatic logic [31:0] ctl(input int ps, input int sel, input bit ie, input bit keep);
    return {24'd0, keep, ie, 1'b0, 2'(sel), 3'(ps)};
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(0, 8'h00, 0, "R1"); step(0, 8'h04, 0, "R1");
    step(0, 8'h08, 0, "R1"); step(0, 8'h4C, 0, "R1");
    // R2 field layout incl. bit 5 read zero
    step(1, 8'h00, 32'hFFFF_FF27, "R2"); step(0, 8'h00, 0, "R2");
    step(1, 8'h00, ctl(0, 0, 0, 0), "R2");
    // R9 upper bits and unmapped
    step(1, 8'h08, 32'hABCD_0004, "R9"); step(0, 8'h08, 0, "R9");
    step(1, 8'h4C, 32'h5555_0001, "R9"); step(0, 8'h4C, 0, "R9");
    step(0, 8'h10, 0, "R9"); step(0, 8'h44, 0, "R9");
    // R6 reload from start value, data ignored
    step(0, 8'h04, 0, "R6");
    step(1, 8'h04, 32'hFFFF_FFFF, "R6"); step(0, 8'h04, 0, "R6");
    // R4 period 4 with start 1, prescaler 1
    step(1, 8'h00, ctl(0, 1, 1, 1), "R4");
    repeat (14) step(0, 8'h04, 0, "R4");
    step(0, 8'h00, 0, "R4");
    // R7 write 1 keeps, write 0 clears
    step(1, 8'h00, ctl(0, 1, 1, 1), "R7"); step(0, 8'h00, 0, "R7");
    // R8 new bounds while running stay inactive
    step(1, 8'h08, 32'd9, "R8"); step(1, 8'h4C, 32'd7, "R8");
    repeat (12) step(0, 8'h04, 0, "R8");
    step(0, 8'h08, 0, "R8");
    // R5 stop with select 2, then 0 transfers bounds
    step(1, 8'h00, ctl(0, 2, 1, 1), "R5");
    repeat (6) step(0, 8'h04, 0, "R5");
    step(1, 8'h00, ctl(0, 0, 1, 1), "R8");
    step(0, 8'h04, 0, "R8"); step(1, 8'h04, 0, "R8");
    // R3 prescaler 2^3
    step(1, 8'h00, ctl(3, 1, 0, 0), "R3");
    repeat (40) step(0, 8'h04, 0, "R3");
    step(1, 8'h00, ctl(7, 1, 0, 0), "R3");
    repeat (300) step(0, 8'h04, 0, "R3");
    // R7 clear colliding with overflow
    step(1, 8'h00, ctl(0, 0, 1, 0), "R7");
    step(1, 8'h08, 32'd1, "R7"); step(1, 8'h4C, 32'd0, "R7");
    step(0, 8'h00, 0, "R7");
    step(1, 8'h00, ctl(0, 1, 1, 0), "R7");
    repeat (12) step(1, 8'h00, ctl(0, 1, 1, 0), "R7");
    step(0, 8'h00, 0, "R7");
    // R6 count write on a wrap tick
    repeat (8) step(1, 8'h04, 0, "R6");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] a;
      r = int'($urandom % 16);
      case ($urandom % 5)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h4C; default: a = 8'h20;
      endcase
      if (r < 2)       step(1, 8'h00, ctl(int'($urandom % 3), ($urandom % 4 == 0) ? int'($urandom % 4) : 1,
                                          1'($urandom), 1'($urandom)), "R2");
      else if (r == 2) step(1, 8'h08, $urandom % 12, "R8");
      else if (r == 3) step(1, 8'h4C, $urandom % 6, "R8");
      else if (r == 4) step(1, 8'h04, $urandom, "R6");
      else             step(0, a, 0, "R4");
    end
    summary();
    $finish;
  end
endmodule